// File: doc/BRIEF.md
# PCI Legacy Interrupt Router

The block steers eight shared, level-sensitive PCI legacy interrupt inputs onto a sixteen-line ISA-style IRQ bus. Each input pin has an 8-bit routing register. The register holds a disable flag and a 4-bit target IRQ number. Software reaches the registers through a small register port that addresses them by pin number, 1 to 8. Inputs and outputs are active-low. An IRQ line is pulled low while any enabled pin routed to it is low, which behaves like a wired-OR of open-drain sources.

A route counts only when the pin is enabled and its target is one of the permitted IRQs. A route that is disabled, or that names a reserved IRQ, asserts nothing. Registers can be rewritten while a pin is asserted. The assertion then leaves the old IRQ and appears on the new IRQ at the same clock edge that accepts the write. A status vector reports which pins currently hold a usable route.

Top module: `pirq_router`

## Requirements
- R1: After reset, every routing register reads 0x80, `irq_n` is all ones and `route_ok` is all zeros.
- R2: A write to pin 1..8 stores bit 7 (disable) and bits 3:0 (target IRQ). Bits 6:4 read back as zero. Read data appears on `reg_rdata` one clock after the cycle where `reg_re` is high.
- R3: For a pin number of 0 or 9..15, a read returns 0x80 and a write changes no register and no status bit.
- R4: `route_ok[p-1]` is high exactly when pin p has bit 7 clear and its target is in the permitted set {3,4,5,6,7,9,10,11,12,14,15} (mask 0xDEF8).
- R5: When pin p has a usable route, driving `pin_n[p-1]` low drives `irq_n[target]` low two clocks later: one clock to sample the input and one clock to register the output.
- R6: A pin whose register is disabled, or names IRQ 0, 1, 2, 8 or 13, leaves every `irq_n` line high.
- R7: Pins routed to the same IRQ merge. The IRQ stays low while at least one of them is low, and returns high only once all of them are high.
- R8: When the register of an asserted pin is rewritten, `irq_n` shows the new route at the clock edge that accepts the write. The old IRQ is released and the new IRQ is asserted if the new route is usable.
- R9: No `irq_n` bit outside mask 0xDEF8 is ever driven low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_pin | input | 4 | Pin number; 1..8 are valid |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| pin_n | input | 8 | Active-low interrupt inputs, bit p-1 is pin p |
| irq_n | output | 16 | Active-low IRQ outputs, bit n is IRQ n |
| route_ok | output | 8 | Per-pin usable-route status |

## Verification
A corrupted routing register is visible at the ports in two ways. It shows on `route_ok` one clock after the write. It shows on `irq_n` as soon as the affected pin is low, at the latest two clocks after the pin falls. A corrupted validity decision shows up the same way, either as a reserved IRQ line falling or as an expected line staying high. The register readback shows the stored value one clock after the request. A stale routing decision during a live rewrite shows on the very edge that accepts the write, because the old IRQ stays low where it should have risen.

// File: rtl/pirq_pkg.sv
package pirq_pkg;
    localparam int          NUM_PINS  = 8;
    localparam int          NUM_IRQS  = 16;
    localparam int          DATA_W    = 8;
    localparam int          ADDR_W    = 4;
    localparam int          SEL_W     = 4;
    localparam int          DIS_BIT   = 7;
    localparam logic [15:0] PERMIT    = 16'hDEF8;
    localparam logic [7:0]  REG_RESET = 8'h80;
    localparam logic [7:0]  KEEP_MASK = 8'h8F;
endpackage

// File: rtl/pirq_regfile.sv
module pirq_regfile
    import pirq_pkg::*;
#(
    parameter int          N_PINS = NUM_PINS,
    parameter int          DW     = DATA_W,
    parameter int          AW     = ADDR_W,
    parameter logic [DW-1:0] RST_VAL = REG_RESET,
    parameter logic [DW-1:0] KEEP    = KEEP_MASK
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic                 re,
    input  logic [AW-1:0]        addr,
    input  logic [DW-1:0]        wdata,
    output logic [DW-1:0]        rdata,
    output logic [N_PINS*DW-1:0] regs_now,
    output logic [N_PINS*DW-1:0] regs_next
);
    typedef struct packed {
        logic [N_PINS-1:0][DW-1:0] regs;
        logic [DW-1:0]             rdata;
    } rf_state_t;

    rf_state_t st_d, st_q;
    logic      in_range;
    logic [AW-1:0] idx;

    assign in_range = (addr >= AW'(1)) && (addr <= AW'(N_PINS));
    assign idx      = addr - AW'(1);

    always_comb begin
        st_d = st_q;
        if (re) begin
            st_d.rdata = RST_VAL;
            for (int p = 0; p < N_PINS; p++) begin
                if (in_range && idx == AW'(p)) begin
                    st_d.rdata = st_q.regs[p];
                end
            end
        end
        if (we && in_range) begin
            for (int p = 0; p < N_PINS; p++) begin
                if (idx == AW'(p)) begin
                    st_d.regs[p] = wdata & KEEP;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.regs  <= {N_PINS{RST_VAL}};
            st_q.rdata <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign regs_now  = st_q.regs;
    assign regs_next = st_d.regs;
endmodule

// File: rtl/pirq_valid.sv
module pirq_valid
    import pirq_pkg::*;
#(
    parameter int          N_PINS = NUM_PINS,
    parameter int          DW     = DATA_W,
    parameter int          SW     = SEL_W,
    parameter int          N_IRQS = NUM_IRQS,
    parameter int          DIS    = DIS_BIT,
    parameter logic [N_IRQS-1:0] ALLOW = PERMIT
) (
    input  logic [N_PINS*DW-1:0] regs,
    output logic [N_PINS-1:0]    ok,
    output logic [N_PINS*SW-1:0] sel
);
    for (genvar p = 0; p < N_PINS; p++) begin : g_pin
        logic [DW-1:0] r;
        logic [SW-1:0] s;
        assign r = regs[p*DW +: DW];
        assign s = r[SW-1:0];
        assign sel[p*SW +: SW] = s;
        assign ok[p] = !r[DIS] && ALLOW[s];
    end
endmodule

// File: rtl/pirq_merge.sv
module pirq_merge
    import pirq_pkg::*;
#(
    parameter int N_PINS = NUM_PINS,
    parameter int N_IRQS = NUM_IRQS,
    parameter int SW     = SEL_W
) (
    input  logic [N_PINS-1:0]    ok,
    input  logic [N_PINS*SW-1:0] sel,
    input  logic [N_PINS-1:0]    active,
    output logic [N_IRQS-1:0]    irq_act
);
    for (genvar i = 0; i < N_IRQS; i++) begin : g_irq
        logic hit;
        always_comb begin
            hit = 1'b0;
            for (int p = 0; p < N_PINS; p++) begin
                if (ok[p] && active[p] && sel[p*SW +: SW] == SW'(i)) begin
                    hit = 1'b1;
                end
            end
        end
        assign irq_act[i] = hit;
    end
endmodule

// File: rtl/pirq_router.sv
module pirq_router
    import pirq_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic                reg_re,
    input  logic [ADDR_W-1:0]   reg_pin,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    input  logic [NUM_PINS-1:0] pin_n,
    output logic [NUM_IRQS-1:0] irq_n,
    output logic [NUM_PINS-1:0] route_ok
);
    localparam int REG_BITS = NUM_PINS * DATA_W;
    localparam int SEL_BITS = NUM_PINS * SEL_W;

    typedef struct packed {
        logic [NUM_PINS-1:0] pin_n;
        logic [NUM_IRQS-1:0] irq_n;
    } io_state_t;

    io_state_t st_d, st_q;

    logic [REG_BITS-1:0] regs_now, regs_next;
    logic [NUM_PINS-1:0] ok_now, ok_next;
    logic [SEL_BITS-1:0] sel_now, sel_next;
    logic [NUM_IRQS-1:0] irq_act;

    pirq_regfile u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .re        (reg_re),
        .addr      (reg_pin),
        .wdata     (reg_wdata),
        .rdata     (reg_rdata),
        .regs_now  (regs_now),
        .regs_next (regs_next)
    );

    // Status follows the stored registers.
    pirq_valid u_valid_now (
        .regs (regs_now),
        .ok   (ok_now),
        .sel  (sel_now)
    );

    // Output routing uses the register value being written this cycle.
    pirq_valid u_valid_next (
        .regs (regs_next),
        .ok   (ok_next),
        .sel  (sel_next)
    );

    pirq_merge u_merge (
        .ok      (ok_next),
        .sel     (sel_next),
        .active  (~st_q.pin_n),
        .irq_act (irq_act)
    );

    always_comb begin
        st_d       = st_q;
        st_d.pin_n = pin_n;
        st_d.irq_n = ~irq_act;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.pin_n <= '1;
            st_q.irq_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign irq_n    = st_q.irq_n;
    assign route_ok = ok_now;

    logic unused_sel;
    assign unused_sel = ^sel_now;
endmodule

// File: rtl/pirq_router_sva.sv
module pirq_router_sva
    import pirq_pkg::*;
(
    input logic                clk,
    input logic                rst_n,
    input logic                reg_we,
    input logic                reg_re,
    input logic [ADDR_W-1:0]   reg_pin,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [NUM_IRQS-1:0] irq_n,
    input logic [NUM_PINS-1:0] route_ok
);
    logic oor;
    assign oor = (reg_pin == '0) || (reg_pin > ADDR_W'(NUM_PINS));

    // R9
    a_r9_no_reserved_irq: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n | PERMIT) == {NUM_IRQS{1'b1}});

    // R3
    a_r3_oor_read: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_re && oor) |=> (reg_rdata == REG_RESET));

    // R3
    a_r3_oor_write: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && oor) |=> $stable(route_ok));

    // R2
    a_r2_mid_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> (reg_rdata[6:4] == 3'b000));

    // R6
    a_r6_irq_needs_route: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n) <= $countones(route_ok));
endmodule

bind pirq_router pirq_router_sva u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_we    (reg_we),
    .reg_re    (reg_re),
    .reg_pin   (reg_pin),
    .reg_rdata (reg_rdata),
    .irq_n     (irq_n),
    .route_ok  (route_ok)
);

// File: tb/tb_pirq_router.sv
`timescale 1ns/1ps
module tb_pirq_router;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [3:0]  reg_pin = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [7:0]  pin_n = 8'hFF;
    logic [15:0] irq_n;
    logic [7:0]  route_ok;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    pirq_router dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
        .reg_pin(reg_pin), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_n(pin_n), .irq_n(irq_n), .route_ok(route_ok)
    );

    // {pin, write data, pin_n pattern, expected irq_n}; applied in order
    localparam int NV = 10;
    localparam logic [35:0] VEC [NV] = '{
        {4'd1, 8'h05, 8'hFE, 16'hFFDF},
        {4'd2, 8'h05, 8'hFD, 16'hFFDF},
        {4'd3, 8'h0E, 8'hFB, 16'hBFFF},
        {4'd4, 8'h08, 8'hF7, 16'hFFFF},
        {4'd5, 8'h8A, 8'hEF, 16'hFFFF},
        {4'd6, 8'h7C, 8'hDF, 16'hEFFF},
        {4'd7, 8'h03, 8'h00, 16'hAFD7},
        {4'd8, 8'h0F, 8'hFF, 16'hFFFF},
        {4'd8, 8'h00, 8'h7F, 16'hFFFF},
        {4'd1, 8'h05, 8'hFC, 16'hFFDF}
    };

    task automatic check(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [3:0] p, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_pin = p; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] p, output logic [7:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_pin = p;
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic settle2();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    initial begin
        logic [7:0] rv;
        logic [7:0] ok_before;
        int bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 irq_n after reset", irq_n, 16'hFFFF);
        check("R1 route_ok after reset", {8'h0, route_ok}, 16'h0000);
        for (int p = 1; p <= 8; p++) begin
            rd(4'(p), rv);
            check("R1 register reset value", {8'h0, rv}, 16'h0080);
        end

        // Table: R2 readback, R5/R6/R7 routing and merge
        for (int v = 0; v < NV; v++) begin
            logic [3:0]  vp;
            logic [7:0]  vd, vpins;
            logic [15:0] vexp;
            {vp, vd, vpins, vexp} = VEC[v];
            wr(vp, vd);
            rd(vp, rv);
            check("R2 stored bits readback", {8'h0, rv}, {8'h0, vd & 8'h8F});
            pin_n = vpins;
            settle2();
            check("R5 R6 R7 table irq_n", irq_n, vexp);
        end

        // R4 status after table: pins 1,2,3,6,7 usable
        check("R4 route_ok", {8'h0, route_ok}, 16'h0067);

        // R3 out-of-range access
        rd(4'd0, rv);  check("R3 read pin 0", {8'h0, rv}, 16'h0080);
        rd(4'd9, rv);  check("R3 read pin 9", {8'h0, rv}, 16'h0080);
        rd(4'd15, rv); check("R3 read pin 15", {8'h0, rv}, 16'h0080);
        ok_before = route_ok;
        wr(4'd0, 8'h80);
        wr(4'd9, 8'h80);
        check("R3 write ignored status", {8'h0, route_ok}, {8'h0, ok_before});
        rd(4'd1, rv);  check("R3 pin1 untouched", {8'h0, rv}, 16'h0005);

        // R7 merge release order (pin1, pin2 both on IRQ 5)
        pin_n = 8'hFC; settle2();
        check("R7 both low", irq_n, 16'hFFDF);
        pin_n = 8'hFD; settle2();
        check("R7 one still low", irq_n, 16'hFFDF);
        pin_n = 8'hFF; settle2();
        check("R7 all released", irq_n, 16'hFFFF);

        // R8 live reroute; checked on the write's own edge
        pin_n = 8'hFE; settle2();
        check("R8 before reroute", irq_n, 16'hFFDF);
        wr(4'd1, 8'h0B);
        check("R8 move to IRQ 11", irq_n, 16'hF7FF);
        wr(4'd1, 8'h0D);
        check("R8 move to reserved 13", irq_n, 16'hFFFF);
        wr(4'd1, 8'h05);
        check("R8 back to IRQ 5", irq_n, 16'hFFDF);
        wr(4'd1, 8'h85);
        check("R6 disabled while asserted", irq_n, 16'hFFFF);

        // R9 random writes and inputs
        bad = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if ((irq_n | 16'hDEF8) !== 16'hFFFF) bad++;
            reg_we    = 1'($urandom);
            reg_pin   = 4'($urandom);
            reg_wdata = 8'($urandom);
            pin_n     = 8'($urandom);
        end
        reg_we = 1'b0;
        check("R9 reserved IRQ never low", 16'(bad), 16'h0000);

        done = 1;
        summary();
    end
endmodule